// File: doc/BRIEF.md
# Prescaled Interval Timer Bank

This block holds a bank of three independent 16-bit up-counters behind a single word-addressed register file. All three share one input clock. Each counter can run straight off that clock or off a power-of-two divider. It either runs free and wraps, or repeats over a programmed interval. When the count lands on any of three compare values it records an event. Events are latched as sticky flags that clear when read. Each counter drives its own interrupt line, which is high while any flag that is unmasked is set.

Software programs a channel by writing its divider setting, interval, compare values and mask, and then writes its control register. One write to the control register can clear the count and start the counter. A timebase counter typically runs free with no interrupt. An event timer runs in interval mode with the interval flag unmasked.

Each channel has a two-state run controller. In `ST_HALT` the count is frozen. `ST_RUN` advances the count on every divider tick. The transition `ST_HALT -> ST_RUN` happens on a control write with the halt bit clear. The transition `ST_RUN -> ST_HALT` happens on a control write with the halt bit set. Reset enters `ST_HALT`.

Top module: `ttc_bank`

## Requirements
- R1: After reset, every channel's control register reads 0x0001 (halted), its count reads 0, and every interrupt line is low.
- R2: Register r of channel t is at word address 3*r + t, which is byte offset 4 times that. The register order r is: 0 divider setting, 1 control, 2 count (read only), 3 interval, 4/5/6 compare A/B/C, 7 flags, 8 mask.
- R3: A running channel with the divider off adds 1 per clock. In free mode it wraps from 0xFFFF to 0 and sets flag bit 4 at that step.
- R4: While control bit 0 (halt) is set, the count holds its value. Writes to the count register have no effect.
- R5: Writing control with bit 4 set zeroes the count and the divider in that cycle. The other control bits (0 halt, 1 interval mode, 3 compare enable) take the written value. Bit 4 always reads back as 0.
- R6: In the divider setting, bit 0 enables the divider and bits [4:1] hold N. With the divider enabled, the count advances once every 2^(N+1) clocks, so 0x9 gives one step per 32 clocks.
- R7: With control bit 1 set, a step taken at count == interval returns the count to 0 and sets flag bit 0. Intervals from 1 to 0xFFFE are valid, and the period is interval+1 steps.
- R8: With control bit 3 set, flag bit 1, 2 or 3 is set when a step makes the count equal compare A, B or C. With bit 3 clear, compares set nothing.
- R9: Reading the flags register returns its bits and clears them. An event in the same cycle as the read stays set. Writes to flags have no effect.
- R10: A channel's interrupt is high exactly while some flag bit and the same mask bit are both 1. Masked events still set their flag.
- R11: Channels run independently. Activity on one never changes another channel's count, flags or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| rd_en | input | 1 | Read strobe; clears flags when addr selects a flags register |
| addr | input | 5 | Word address (3*register + channel) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr, 0 for unmapped words |
| irq | output | 3 | One interrupt line per channel |

## Verification
On every cycle, the assertions check four things. A halted count stays still. A running count only steps by one, holds, or returns to zero. A raised interval flag coincides with a zero count. With the divider enabled, ticks never come on back-to-back cycles. They also check that an interrupt never rises while the mask is zero. The bench scenarios are needed to show exact timing. That covers the 32-clock step at setting 0x9, the interval period of interval+1 steps, the wrap flag after 65536 steps, and read-to-clear ordering. The scenarios also cover address mapping across channels, and the ignored writes to the count and flags registers.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
    localparam int NUM_MATCH = 3;
    localparam int NUM_REG   = 9;
    localparam int PS_SEL_W  = 4;
    localparam int PS_W      = 2 ** PS_SEL_W;
    localparam int STS_W     = NUM_MATCH + 2;
    localparam int CFG_W     = PS_SEL_W + 1;

    // register order inside one channel (word index = id*channels + channel)
    localparam int RG_DIV   = 0;
    localparam int RG_CTRL  = 1;
    localparam int RG_COUNT = 2;
    localparam int RG_LIMIT = 3;
    localparam int RG_CMP0  = 4;
    localparam int RG_FLAGS = 7;
    localparam int RG_MASK  = 8;

    // control bits
    localparam int CTL_HALT  = 0;
    localparam int CTL_LIMIT = 1;
    localparam int CTL_CMP   = 3;
    localparam int CTL_ZERO  = 4;

    // flag bits
    localparam int FLG_LIMIT = 0;
    localparam int FLG_CMP0  = 1;
    localparam int FLG_WRAP  = NUM_MATCH + 1;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;
endpackage

// File: rtl/ttc_prescaler.sv
module ttc_prescaler
    import ttc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                clr,
    input  logic                div_en,
    input  logic [PS_SEL_W-1:0] div_sel,
    output logic                tick
);
    logic [PS_W-1:0] acc;
    logic [PS_W-1:0] lim;

    // terminal value 2^(N+1)-1
    always_comb begin
        lim  = {PS_W{1'b1}} >> (PS_SEL_W'(PS_W - 1) - div_sel);
        tick = run && (!div_en || (acc >= lim));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (run && div_en) begin
            acc <= tick ? '0 : acc + 1'b1;
        end
    end
endmodule

// File: rtl/ttc_counter.sv
module ttc_counter
    import ttc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ctl_wr,
    input  logic                            ctl_halt,
    input  logic                            ctl_zero,
    input  logic                            tick,
    input  logic                            limit_mode,
    input  logic                            cmp_en,
    input  logic [CNT_W-1:0]                limit,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] cmp,
    output logic                            running,
    output logic [CNT_W-1:0]                count,
    output logic [STS_W-1:0]                events
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    run_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (ctl_wr && !ctl_halt) st_d = ST_RUN;
            ST_RUN:  if (ctl_wr && ctl_halt)  st_d = ST_HALT;
            default: st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    always_comb begin
        running = (st_q == ST_RUN);
        cnt_d   = count;
        events  = '0;
        if (ctl_wr && ctl_zero) begin
            cnt_d = '0;
        end else if (tick) begin
            if (limit_mode && (count == limit)) begin
                cnt_d             = '0;
                events[FLG_LIMIT] = 1'b1;
            end else begin
                cnt_d = count + 1'b1;
                if (!limit_mode && (count == CNT_MAX)) events[FLG_WRAP] = 1'b1;
            end
            for (int k = 0; k < NUM_MATCH; k++) begin
                if (cmp_en && (cnt_d == cmp[k])) events[FLG_CMP0 + k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= cnt_d;
    end
endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
    import ttc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [NUM_REG-1:0] sel,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rd_val,
    output logic               irq,
    output logic [CNT_W-1:0]   count,
    output logic               running,
    output logic               tick,
    output logic               div_en,
    output logic [STS_W-1:0]   flags,
    output logic [STS_W-1:0]   mask
);
    logic [CFG_W-1:0]                div_cfg;
    logic                            limit_mode;
    logic                            cmp_en;
    logic [CNT_W-1:0]                limit;
    logic [NUM_MATCH-1:0][CNT_W-1:0] cmp;
    logic [STS_W-1:0]                events;
    logic                            ctl_wr;

    assign ctl_wr = wr_en && sel[RG_CTRL];
    assign div_en = div_cfg[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cfg    <= '0;
            limit_mode <= 1'b0;
            cmp_en     <= 1'b0;
            limit      <= '0;
            mask       <= '0;
        end else if (wr_en) begin
            if (sel[RG_DIV])   div_cfg <= wdata[CFG_W-1:0];
            if (sel[RG_LIMIT]) limit   <= wdata;
            if (sel[RG_MASK])  mask    <= wdata[STS_W-1:0];
            if (sel[RG_CTRL]) begin
                limit_mode <= wdata[CTL_LIMIT];
                cmp_en     <= wdata[CTL_CMP];
            end
        end
    end

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cmp[k] <= '0;
            else if (wr_en && sel[RG_CMP0 + k]) cmp[k] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       flags <= '0;
        else if (rd_en && sel[RG_FLAGS])  flags <= events;
        else                              flags <= flags | events;
    end

    ttc_prescaler u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .clr     (ctl_wr && wdata[CTL_ZERO]),
        .div_en  (div_en),
        .div_sel (div_cfg[CFG_W-1:1]),
        .tick    (tick)
    );

    ttc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_halt   (wdata[CTL_HALT]),
        .ctl_zero   (wdata[CTL_ZERO]),
        .tick       (tick),
        .limit_mode (limit_mode),
        .cmp_en     (cmp_en),
        .limit      (limit),
        .cmp        (cmp),
        .running    (running),
        .count      (count),
        .events     (events)
    );

    always_comb begin
        rd_val = '0;
        if (sel[RG_DIV])   rd_val = CNT_W'(div_cfg);
        if (sel[RG_CTRL]) begin
            rd_val[CTL_HALT]  = !running;
            rd_val[CTL_LIMIT] = limit_mode;
            rd_val[CTL_CMP]   = cmp_en;
        end
        if (sel[RG_COUNT]) rd_val = count;
        if (sel[RG_LIMIT]) rd_val = limit;
        for (int k = 0; k < NUM_MATCH; k++) begin
            if (sel[RG_CMP0 + k]) rd_val = cmp[k];
        end
        if (sel[RG_FLAGS]) rd_val = CNT_W'(flags);
        if (sel[RG_MASK])  rd_val = CNT_W'(mask);
    end

    assign irq = |(flags & mask);
endmodule

// File: rtl/ttc_bank.sv
module ttc_bank
    import ttc_pkg::*;
#(
    parameter  int NUM_TMR = 3,
    parameter  int CNT_W   = 16,
    localparam int AW      = $clog2(NUM_REG * NUM_TMR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rdata,
    output logic [NUM_TMR-1:0] irq
);
    logic [NUM_TMR-1:0][NUM_REG-1:0] sel_a;
    logic [NUM_TMR-1:0][CNT_W-1:0]   rd_a;
    logic [NUM_TMR-1:0][CNT_W-1:0]   count_a;
    logic [NUM_TMR-1:0]              run_a;
    logic [NUM_TMR-1:0]              tick_a;
    logic [NUM_TMR-1:0]              div_a;
    logic [NUM_TMR-1:0][STS_W-1:0]   flags_a;
    logic [NUM_TMR-1:0][STS_W-1:0]   mask_a;

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_ch
        for (genvar r = 0; r < NUM_REG; r++) begin : g_sel
            assign sel_a[t][r] = (addr == AW'(r * NUM_TMR + t));
        end

        ttc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .rd_en   (rd_en),
            .sel     (sel_a[t]),
            .wdata   (wdata),
            .rd_val  (rd_a[t]),
            .irq     (irq[t]),
            .count   (count_a[t]),
            .running (run_a[t]),
            .tick    (tick_a[t]),
            .div_en  (div_a[t]),
            .flags   (flags_a[t]),
            .mask    (mask_a[t])
        );
    end

    always_comb begin
        rdata = '0;
        for (int t = 0; t < NUM_TMR; t++) rdata = rdata | rd_a[t];
    end
endmodule

// File: rtl/ttc_bank_chk.sv
module ttc_bank_chk
    import ttc_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [NUM_TMR-1:0]              irq,
    input logic [NUM_TMR-1:0][CNT_W-1:0]   count_a,
    input logic [NUM_TMR-1:0]              run_a,
    input logic [NUM_TMR-1:0]              tick_a,
    input logic [NUM_TMR-1:0]              div_a,
    input logic [NUM_TMR-1:0][STS_W-1:0]   flags_a,
    input logic [NUM_TMR-1:0][STS_W-1:0]   mask_a
);
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
        AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_a[t] && !wr_en) |=> $stable(count_a[t])); // R4
        AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
            (run_a[t] && !wr_en) |=> (count_a[t] == $past(count_a[t]) || count_a[t] == $past(count_a[t]) + 1'b1 || count_a[t] == '0)); // R3
        AST_LIMIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_a[t][FLG_LIMIT]) |-> (count_a[t] == '0)); // R7
        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            irq[t] |-> (mask_a[t] != '0)); // R10
        AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_a[t] && div_a[t] && !wr_en) |=> !tick_a[t]); // R6
    end
endmodule

bind ttc_bank ttc_bank_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .irq     (irq),
    .count_a (count_a),
    .run_a   (run_a),
    .tick_a  (tick_a),
    .div_a   (div_a),
    .flags_a (flags_a),
    .mask_a  (mask_a)
);

// File: tb/ttc_bank_bench.sv
module ttc_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 3;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [NT-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ttc_bank #(.NUM_TMR(NT), .CNT_W(16)) u_ttc_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input int r, input int t, input logic [15:0] v);
        addr = AW'(r * NT + t); wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int r, input int t, output logic [15:0] v);
        addr = AW'(r * NT + t); rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int t = 0; t < NT; t++) begin
            rd(1, t, v); chk("R1 ctrl reset", v, 16'h0001);
            rd(2, t, v); chk("R1 count reset", v, 16'h0000);
        end
        chk("R1 irq reset", 16'(irq), 16'h0000);
    endtask

    task automatic t_free_hold();
        logic [15:0] v, h;
        wr(0, 0, 16'h0000);
        wr(1, 0, 16'h0010);
        repeat (9) @(negedge clk);
        rd(2, 0, v); chk("R3 step per clock", v, 16'd9);
        rd(2, 0, v); chk("R3 next step", v, 16'd10);
        wr(1, 0, 16'h0001);
        rd(2, 0, h);
        repeat (5) @(negedge clk);
        rd(2, 0, v); chk("R4 halted holds", v, h);
        wr(2, 0, 16'h1234);
        rd(2, 0, v); chk("R4 count write ignored", v, h);
        wr(1, 0, 16'h001B);
        rd(1, 0, v); chk("R5 zero bit reads 0", v, 16'h000B);
        rd(2, 0, v); chk("R5 count zeroed", v, 16'h0000);
        wr(1, 0, 16'h0001);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        wr(0, 0, 16'h0009);
        wr(1, 0, 16'h0010);
        repeat (63) @(negedge clk);
        rd(2, 0, v); chk("R6 div32 after 63", v, 16'd1);
        rd(2, 0, v); chk("R6 div32 after 64", v, 16'd2);
        wr(0, 0, 16'h0001);
        wr(1, 0, 16'h0010);
        repeat (6) @(negedge clk);
        rd(2, 0, v); chk("R6 div2 after 6", v, 16'd3);
        wr(1, 0, 16'h0001);
        wr(0, 0, 16'h0000);
    endtask

    task automatic t_interval();
        logic [15:0] v;
        wr(8, 0, 16'h0001);
        wr(3, 0, 16'd3);
        wr(1, 0, 16'h0012);
        repeat (3) @(negedge clk);
        chk("R7 no irq before limit", 16'(irq[0]), 16'h0000);
        rd(2, 0, v); chk("R7 count at limit", v, 16'd3);
        chk("R10 irq at limit", 16'(irq[0]), 16'h0001);
        rd(2, 0, v); chk("R7 count back to 0", v, 16'd0);
        wr(1, 0, 16'h0003);
        rd(7, 0, v); chk("R9 flags read", v, 16'h0001);
        chk("R9 irq drops after read", 16'(irq[0]), 16'h0000);
        rd(7, 0, v); chk("R9 flags cleared", v, 16'h0000);
        // shortest interval
        wr(3, 0, 16'd1);
        wr(1, 0, 16'h0012);
        @(negedge clk);
        chk("R7 limit1 first step", 16'(irq[0]), 16'h0000);
        @(negedge clk);
        chk("R7 limit1 second step", 16'(irq[0]), 16'h0001);
        wr(1, 0, 16'h0003);
        rd(7, 0, v); chk("R7 limit1 flag", v, 16'h0001);
        // masked
        wr(8, 0, 16'h0000);
        wr(1, 0, 16'h0012);
        repeat (6) @(negedge clk);
        chk("R10 masked irq low", 16'(irq[0]), 16'h0000);
        wr(1, 0, 16'h0003);
        rd(7, 0, v); chk("R10 masked flag set", v, 16'h0001);
        wr(7, 0, 16'h001F);
        rd(7, 0, v); chk("R9 flags write ignored", v, 16'h0000);
    endtask

    task automatic t_match();
        logic [15:0] v;
        wr(4, 0, 16'd5);
        wr(5, 0, 16'd200);
        wr(6, 0, 16'd300);
        wr(1, 0, 16'h0018);
        rd(1, 0, v); chk("R5 ctrl readback", v, 16'h0008);
        repeat (7) @(negedge clk);
        wr(1, 0, 16'h0009);
        rd(7, 0, v); chk("R8 compare A flag", v, 16'h0002);
        wr(1, 0, 16'h0010);
        repeat (8) @(negedge clk);
        wr(1, 0, 16'h0001);
        rd(7, 0, v); chk("R8 compare disabled", v, 16'h0000);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        wr(8, 0, 16'h0010);
        wr(1, 0, 16'h0010);
        repeat (65535) @(negedge clk);
        chk("R3 no wrap irq yet", 16'(irq[0]), 16'h0000);
        rd(2, 0, v); chk("R3 count at max", v, 16'hFFFF);
        chk("R10 wrap irq", 16'(irq[0]), 16'h0001);
        rd(2, 0, v); chk("R3 wrapped to 0", v, 16'h0000);
        wr(1, 0, 16'h0001);
        rd(7, 0, v); chk("R3 wrap flag", v, 16'h0010);
        wr(8, 0, 16'h0000);
    endtask

    task automatic t_indep();
        logic [15:0] v, c0;
        rd(2, 0, c0);
        wr(0, 1, 16'h0000);
        wr(3, 1, 16'd4);
        wr(8, 1, 16'h0001);
        wr(1, 1, 16'h0012);
        repeat (4) @(negedge clk);
        chk("R11 ch1 before limit", 16'(irq[1]), 16'h0000);
        @(negedge clk);
        chk("R2 ch1 irq at limit", 16'(irq[1]), 16'h0001);
        chk("R11 ch0 irq quiet", 16'(irq[0]), 16'h0000);
        rd(2, 0, v); chk("R11 ch0 count unchanged", v, c0);
        rd(2, 2, v); chk("R11 ch2 count unchanged", v, 16'h0000);
        wr(1, 1, 16'h0003);
        rd(7, 1, v); chk("R2 ch1 flags", v, 16'h0001);
        rd(7, 0, v); chk("R11 ch0 flags clear", v, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free_hold();
        t_prescale();
        t_interval();
        t_match();
        t_wrap();
        t_indep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule